// File: doc/BRIEF.md
# Longest Prefix Match Route Lookup

This block resolves an IPv4 destination address to a forwarding decision: a next-hop address and a bitmap of output ports. It holds a small table of routes. Each route has a subnet address, a subnet mask, a next-hop address, an output-port bitmap and a valid flag. Software fills the table one slot at a time through a plain write port. A write is a single cycle that carries the slot index and all fields of the route.

Software places routes in descending order of prefix length, so slot 0 holds the most specific route. The block compares the address with every slot in parallel and picks the matching slot with the lowest index. That slot is therefore the longest matching prefix. A route with mask 0 placed last matches every address and acts as the default route. A next-hop of 0.0.0.0 marks a directly connected subnet; in that case the looked-up address is returned as the next hop.

Requests enter on a valid/ready stream and results leave on a valid/ready stream. A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. Its result is presented one cycle later and held until the consumer raises `rsp_ready`. While a result waits, `req_ready` stays low, so back-pressure passes straight upstream. When the consumer is ready, one lookup can be accepted every cycle.

Top module: `lpm_lookup`

## Requirements
- R1: After reset `rsp_valid` is 0, `req_ready` is 1 and every table slot is invalid, so any lookup misses.
- R2: A slot matches an address when its valid flag is set and (address AND mask) equals (subnet AND mask).
- R3: When several slots match, the one with the lowest index is returned. With routes written longest prefix first, this gives the longest prefix match.
- R4: A valid slot with mask 0x00000000 matches every address and serves as the default route.
- R5: When no slot matches, `rsp_hit` is 0 and `rsp_next_hop` and `rsp_ports` are all zeros.
- R6: When the winning slot's next-hop field is 0x00000000, `rsp_next_hop` equals the looked-up address. Otherwise it equals the stored next-hop.
- R7: A result appears with `rsp_valid` high on the first rising edge after the request is accepted.
- R8: While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is 0 and `rsp_hit`, `rsp_next_hop` and `rsp_ports` hold their values.
- R9: A write replaces all fields of the addressed slot, and a write with the valid flag at 0 removes the route. A lookup accepted on the same edge as a write sees the old contents; later lookups see the new contents.
- R10: After a result is consumed (`rsp_ready` high), `rsp_valid` falls on the next edge unless a new request is accepted on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | $clog2(ENTRIES) | Slot index to write |
| tbl_valid | input | 1 | Valid flag for the written route |
| tbl_subnet | input | 32 | Subnet address of the route |
| tbl_mask | input | 32 | Subnet mask of the route |
| tbl_next_hop | input | 32 | Next-hop address (0 = directly connected) |
| tbl_ports | input | PORT_W | Output-port bitmap of the route |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Destination address to look up |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_hit | output | 1 | A route matched |
| rsp_next_hop | output | 32 | Resolved next-hop address |
| rsp_ports | output | PORT_W | Output-port bitmap of the winning route |

## Verification
The lookups use one table with nested /24, /16 and /8 routes. Addresses fall inside the innermost route, inside only the outer ones, and outside all of them. These cases tell a lowest-index winner apart from a match on any matching slot, and a masked compare apart from a full-width compare. The same addresses are repeated after a mask-0 default route is added and after the /24 slot is invalidated. These repeats separate a real miss from a default hit and show that clearing the valid flag removes a route. Two further patterns cover the remaining timing rules. A stalled consumer must see the result frozen and the request side closed. A write and a lookup on the same edge must return the old route, and the next lookup must return the new one.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int IP_W = 32;

  function automatic logic prefix_hit(input logic [IP_W-1:0] addr,
                                      input logic [IP_W-1:0] subnet,
                                      input logic [IP_W-1:0] mask);
    return (addr & mask) == (subnet & mask);
  endfunction
endpackage

// File: rtl/lpm_table.sv
module lpm_table
  import lpm_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int PORT_W  = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic              w_valid,
  input  logic [IP_W-1:0]   w_subnet,
  input  logic [IP_W-1:0]   w_mask,
  input  logic [IP_W-1:0]   w_next_hop,
  input  logic [PORT_W-1:0] w_ports,
  output logic [ENTRIES-1:0] slot_valid,
  output logic [IP_W-1:0]   slot_subnet   [ENTRIES],
  output logic [IP_W-1:0]   slot_mask     [ENTRIES],
  output logic [IP_W-1:0]   slot_next_hop [ENTRIES],
  output logic [PORT_W-1:0] slot_ports    [ENTRIES]
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_valid[g]    <= 1'b0;
        slot_subnet[g]   <= '0;
        slot_mask[g]     <= '0;
        slot_next_hop[g] <= '0;
        slot_ports[g]    <= '0;
      end else if (we && idx == IDX_W'(g)) begin
        slot_valid[g]    <= w_valid;
        slot_subnet[g]   <= w_subnet;
        slot_mask[g]     <= w_mask;
        slot_next_hop[g] <= w_next_hop;
        slot_ports[g]    <= w_ports;
      end
    end
  end
endmodule

// File: rtl/lpm_match.sv
module lpm_match
  import lpm_pkg::*;
#(
  parameter int ENTRIES = 32
) (
  input  logic [IP_W-1:0]    addr,
  input  logic [ENTRIES-1:0] slot_valid,
  input  logic [IP_W-1:0]    slot_subnet [ENTRIES],
  input  logic [IP_W-1:0]    slot_mask   [ENTRIES],
  output logic [ENTRIES-1:0] hits
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hits[g] = slot_valid[g] && prefix_hit(addr, slot_subnet[g], slot_mask[g]);
  end
endmodule

// File: rtl/lpm_first.sv
module lpm_first #(
  parameter int N = 32,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vec,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end
  assign any = |vec;
endmodule

// File: rtl/lpm_lookup.sv
module lpm_lookup
  import lpm_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int PORT_W  = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tbl_we,
  input  logic [IDX_W-1:0]  tbl_idx,
  input  logic              tbl_valid,
  input  logic [31:0]       tbl_subnet,
  input  logic [31:0]       tbl_mask,
  input  logic [31:0]       tbl_next_hop,
  input  logic [PORT_W-1:0] tbl_ports,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic [31:0]       rsp_next_hop,
  output logic [PORT_W-1:0] rsp_ports
);
  logic [ENTRIES-1:0] s_valid;
  logic [IP_W-1:0]    s_subnet   [ENTRIES];
  logic [IP_W-1:0]    s_mask     [ENTRIES];
  logic [IP_W-1:0]    s_next_hop [ENTRIES];
  logic [PORT_W-1:0]  s_ports    [ENTRIES];
  logic [ENTRIES-1:0] hits;
  logic               any_hit;
  logic [IDX_W-1:0]   win;
  logic               accept;
  logic [IP_W-1:0]    nh_sel;

  lpm_table #(.ENTRIES(ENTRIES), .PORT_W(PORT_W)) u_table (
    .clk(clk), .rst_n(rst_n), .we(tbl_we), .idx(tbl_idx),
    .w_valid(tbl_valid), .w_subnet(tbl_subnet), .w_mask(tbl_mask),
    .w_next_hop(tbl_next_hop), .w_ports(tbl_ports),
    .slot_valid(s_valid), .slot_subnet(s_subnet), .slot_mask(s_mask),
    .slot_next_hop(s_next_hop), .slot_ports(s_ports)
  );

  lpm_match #(.ENTRIES(ENTRIES)) u_match (
    .addr(req_addr), .slot_valid(s_valid), .slot_subnet(s_subnet),
    .slot_mask(s_mask), .hits(hits)
  );

  lpm_first #(.N(ENTRIES)) u_first (
    .vec(hits), .any(any_hit), .idx(win)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign nh_sel    = (s_next_hop[win] == '0) ? req_addr : s_next_hop[win];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_next_hop <= '0;
      rsp_ports    <= '0;
    end else if (accept) begin
      rsp_valid    <= 1'b1;
      rsp_hit      <= any_hit;
      rsp_next_hop <= any_hit ? nh_sel : '0;
      rsp_ports    <= any_hit ? s_ports[win] : '0;
    end else if (rsp_ready) begin
      rsp_valid    <= 1'b0;
    end
  end
endmodule

// File: rtl/lpm_lookup_chk.sv
module lpm_lookup_chk #(
  parameter int PORT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_hit,
  input logic [31:0]       rsp_next_hop,
  input logic [PORT_W-1:0] rsp_ports
);
  p_miss_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_next_hop == '0 && rsp_ports == '0));

  p_accept_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  p_stall_closed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_hit) && $stable(rsp_next_hop) && $stable(rsp_ports)));

  p_drain_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready && !req_valid) |=> !rsp_valid);
endmodule

bind lpm_lookup lpm_lookup_chk #(.PORT_W(PORT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
  .rsp_next_hop(rsp_next_hop), .rsp_ports(rsp_ports)
);

// File: tb/lpm_lookup_tb.sv
module lpm_lookup_tb;
  localparam int ENTRIES = 32;
  localparam int PORT_W  = 8;
  localparam int IDX_W   = $clog2(ENTRIES);

  logic clk = 0;
  logic rst_n = 0;
  logic tbl_we = 0;
  logic [IDX_W-1:0] tbl_idx = '0;
  logic tbl_valid = 0;
  logic [31:0] tbl_subnet = '0, tbl_mask = '0, tbl_next_hop = '0;
  logic [PORT_W-1:0] tbl_ports = '0;
  logic req_valid = 0;
  logic req_ready;
  logic [31:0] req_addr = '0;
  logic rsp_valid;
  logic rsp_ready = 1;
  logic rsp_hit;
  logic [31:0] rsp_next_hop;
  logic [PORT_W-1:0] rsp_ports;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  lpm_lookup #(.ENTRIES(ENTRIES), .PORT_W(PORT_W)) u_dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_route(input int idx, input logic v, input logic [31:0] sn,
                             input logic [31:0] mk, input logic [31:0] nh,
                             input logic [PORT_W-1:0] pt);
    @(negedge clk);
    tbl_we = 1; tbl_idx = IDX_W'(idx); tbl_valid = v;
    tbl_subnet = sn; tbl_mask = mk; tbl_next_hop = nh; tbl_ports = pt;
    @(negedge clk);
    tbl_we = 0;
  endtask

  task automatic lookup(input string req, input logic [31:0] addr, input logic hit,
                        input logic [31:0] nh, input logic [PORT_W-1:0] pt);
    @(negedge clk);
    rsp_ready = 1; req_valid = 1; req_addr = addr;
    @(negedge clk);
    req_valid = 0;
    check({req, " R7 rsp_valid"}, 32'(rsp_valid), 32'd1);
    check({req, " hit"}, 32'(rsp_hit), 32'(hit));
    check({req, " next_hop"}, rsp_next_hop, nh);
    check({req, " ports"}, 32'(rsp_ports), 32'(pt));
  endtask

  task automatic t_reset();
    check("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    check("R1 req_ready after reset", 32'(req_ready), 32'd1);
    lookup("R1 R5 empty table", 32'h0A010205, 1'b0, 32'h0, 8'h00);
  endtask

  task automatic t_nested();
    write_route(0, 1, 32'h0A010200, 32'hFFFFFF00, 32'hC0A80001, 8'h01);
    write_route(1, 1, 32'h0A010000, 32'hFFFF0000, 32'hC0A80002, 8'h02);
    write_route(2, 1, 32'h0A000000, 32'hFF000000, 32'h00000000, 8'h04);
    lookup("R3 /24 wins", 32'h0A010205, 1'b1, 32'hC0A80001, 8'h01);
    lookup("R2 R3 /16 wins", 32'h0A010909, 1'b1, 32'hC0A80002, 8'h02);
    lookup("R6 direct /8", 32'h0A070707, 1'b1, 32'h0A070707, 8'h04);
    lookup("R5 outside all", 32'h0B000001, 1'b0, 32'h0, 8'h00);
  endtask

  task automatic t_default();
    write_route(3, 1, 32'h0, 32'h0, 32'h01010101, 8'h80);
    lookup("R4 default route", 32'h0B000001, 1'b1, 32'h01010101, 8'h80);
    lookup("R3 R4 /24 over default", 32'h0A010205, 1'b1, 32'hC0A80001, 8'h01);
  endtask

  task automatic t_invalidate();
    write_route(0, 0, 32'h0A010200, 32'hFFFFFF00, 32'hC0A80001, 8'h01);
    lookup("R9 removed /24", 32'h0A010205, 1'b1, 32'hC0A80002, 8'h02);
  endtask

  task automatic t_backpressure();
    logic [31:0] nh0;
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_addr = 32'h0A010909;
    @(negedge clk);
    req_valid = 0;
    check("R7 valid after accept", 32'(rsp_valid), 32'd1);
    nh0 = rsp_next_hop;
    check("R8 stalled next_hop", nh0, 32'hC0A80002);
    for (int i = 0; i < 3; i++) begin
      req_valid = 1; req_addr = 32'h0B000001;
      @(negedge clk);
      check("R8 req_ready low", 32'(req_ready), 32'd0);
      check("R8 valid held", 32'(rsp_valid), 32'd1);
      check("R8 next_hop held", rsp_next_hop, nh0);
      check("R8 ports held", 32'(rsp_ports), 32'h02);
    end
    req_valid = 0; rsp_ready = 1;
    @(negedge clk);
    check("R10 valid drops", 32'(rsp_valid), 32'd0);
  endtask

  task automatic t_race();
    @(negedge clk);
    tbl_we = 1; tbl_idx = IDX_W'(1); tbl_valid = 1;
    tbl_subnet = 32'h0A010000; tbl_mask = 32'hFFFF0000;
    tbl_next_hop = 32'h02020202; tbl_ports = 8'h20;
    rsp_ready = 1; req_valid = 1; req_addr = 32'h0A010909;
    @(negedge clk);
    tbl_we = 0; req_valid = 0;
    check("R9 same-edge old next_hop", rsp_next_hop, 32'hC0A80002);
    check("R9 same-edge old ports", 32'(rsp_ports), 32'h02);
    lookup("R9 later sees new", 32'h0A010909, 1'b1, 32'h02020202, 8'h20);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_nested();
    t_default();
    t_invalidate();
    t_backpressure();
    t_race();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule